// File: doc/BRIEF.md
# Dual-Mode Instruction Pair Sequencer

This block sits at the front of a core that fetches instructions two at a time. Each cycle it takes the 64-bit doubleword fetched at the current program counter and issues one 32-bit half of it. When the counter points at the first word of the doubleword, the low half goes out and then the high half. When the counter points at the second word, only the high half goes out. The outcome of each half comes back in the same cycle: a trap, a redirect to a new target, or nothing. From that outcome the sequencer picks the next counter value.

The sequencer also tracks the dual-instruction mode of the core, which has three states: single (0), transitional (1) and full dual (2). The low half of each pair carries decode flags that say whether the pair counts as a dual operation. At the end of each pair the mode moves one step toward full or toward single. The transitional state lasts exactly one pair.

External interrupt requests are sampled only on the high half of a pair, only in single mode, and only when execution reports no trap of its own. A flag that marks a deferred condition-code result is cleared at the start of every pair.

Top module: `dimode_pair_seq`

## Requirements
- R1: Synchronous active-high reset sets the program counter (`fetch_addr`) to the trap vector 0xFFFFFF00, sets `mode_state` to 0 (single) and clears `cc_defer_valid`.
- R2: While `fetch_valid` is high, `issue_word` is `fetch_data[31:0]` when bit 2 of `fetch_addr` is 0 and `fetch_data[63:32]` when it is 1. `issue_hi` equals bit 2 of `fetch_addr`.
- R3: While `fetch_valid` is low, `issue_valid`, `pair_end`, `trap_enter` and `irq_trap` are low. The counter, the mode and the condition-code flag keep their values.
- R4: When an issued half has no trap, no interrupt and no redirect, `next_pc` is `fetch_addr + 4` and becomes `fetch_addr` at the next edge.
- R5: When an issued half has a redirect and no trap, `next_pc` is `ex_target` and the pair ends.
- R6: `trap_enter` is high on an issued half with `ex_trap` or `irq_trap`. `next_pc` is then 0xFFFFFF00 and the mode returns to 0 (single), whatever the pair's dual flag. A trap takes priority over a redirect.
- R7: `irq_trap` is high only when all of these hold: the issued half is the high half, the mode is 0, `ext_irq` is high and `ex_trap` is low.
- R8: A pair is a dual operation when its low half is issued with `dec_dual_fp` high, or with `dec_dual_nop` high while the mode is not 0. The flags on a high half are ignored. A pair entered at its high half is never dual.
- R9: When a pair ends without a trap, the mode changes as follows. Single (0) goes to transitional (1) if the pair is dual. Transitional goes to full (2) if the pair is dual and to single otherwise. Full goes to transitional if the pair is not dual and stays full if it is. Code 3 never appears.
- R10: `cc_defer_valid` is cleared at the first issued half of each pair and set by `ex_cc_defer` on any issued half of that pair. It is visible from the following cycle.
- R11: `pair_end` is high on an issued high half, and on an issued low half that has a trap or a redirect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_valid | input | 1 | Fetch data for `fetch_addr` is present this cycle |
| fetch_data | input | 64 | Doubleword fetched at `fetch_addr` |
| dec_dual_fp | input | 1 | Issued half decodes as a dual-mode floating-point op |
| dec_dual_nop | input | 1 | Issued half decodes as the dual-mode floating-point nop |
| ex_trap | input | 1 | Execution of the issued half raised a trap |
| ex_redirect | input | 1 | Execution of the issued half changed the flow |
| ex_target | input | 32 | Redirect target address |
| ex_cc_defer | input | 1 | Issued half produced a deferred condition-code result |
| ext_irq | input | 1 | External interrupt request (level) |
| fetch_addr | output | 32 | Current program counter, used as the fetch address |
| issue_valid | output | 1 | A half is issued this cycle |
| issue_word | output | 32 | Issued 32-bit instruction |
| issue_hi | output | 1 | The issued half is the high half |
| next_pc | output | 32 | Counter value taken at the next edge |
| mode_state | output | 2 | 0 single, 1 transitional, 2 full dual |
| pair_end | output | 1 | The issued half closes its pair |
| trap_enter | output | 1 | Trap entry on this half |
| irq_trap | output | 1 | The trap comes from the external interrupt |
| cc_defer_valid | output | 1 | Deferred condition-code flag for the current pair |

## Verification
A directed walk first drives the mode through single, transitional, full, transitional and single. In that walk, a dual nop in single mode shows that the nop only counts once the core is already in dual mode. An interrupt request on a low half and in full mode shows the sampling gate. A stall cycle shows that the state holds. A long run from a fixed seed then mixes stalls, traps, redirects to both word positions, dual flags and interrupts. That run separates trap priority over redirect, pairs entered at their high half from pairs entered at their low half, and flag clearing at pair boundaries from clearing at every half.

// File: rtl/dimode_seq_pkg.sv
package dimode_seq_pkg;

    typedef enum logic [1:0] {
        MODE_NONE  = 2'd0,
        MODE_TRANS = 2'd1,
        MODE_FULL  = 2'd2
    } dmode_e;

    // Resolution of one issued half.
    typedef struct packed {
        logic trap;     // trap entry (execution or interrupt)
        logic irq;      // trap caused by the external request
        logic ends;     // half closes its pair
    } half_result_t;

    function automatic dmode_e mode_after_pair(dmode_e cur, logic dual);
        case (cur)
            MODE_NONE:  return dual ? MODE_TRANS : MODE_NONE;
            MODE_TRANS: return dual ? MODE_FULL  : MODE_NONE;
            MODE_FULL:  return dual ? MODE_FULL  : MODE_TRANS;
            default:    return MODE_NONE;
        endcase
    endfunction

    // The nop only counts once dual mode is already on.
    function automatic logic marks_dual(logic fp_op, logic fp_nop, dmode_e cur);
        return fp_op | (fp_nop & (cur != MODE_NONE));
    endfunction

endpackage

// File: rtl/half_pick.sv
module half_pick #(
    parameter int INSN_W = 32
) (
    input  logic [2*INSN_W-1:0] pair_word,
    input  logic                sel_hi,
    output logic [INSN_W-1:0]   word
);
    logic [INSN_W-1:0] halves [2];

    for (genvar h = 0; h < 2; h++) begin : g_half
        assign halves[h] = pair_word[h*INSN_W +: INSN_W];
    end

    assign word = halves[sel_hi];
endmodule

// File: rtl/pair_ctrl.sv
module pair_ctrl
    import dimode_seq_pkg::*;
#(
    parameter int              ADDR_W   = 32,
    parameter int              HALF_BIT = 2,
    parameter logic [ADDR_W-1:0] STEP   = 4,
    parameter logic [ADDR_W-1:0] TRAP_VEC = '1
) (
    input  logic              fire,
    input  logic [ADDR_W-1:0] pc,
    input  logic              in_pair,
    input  logic              pair_dual_q,
    input  dmode_e            mode,
    input  logic              dual_fp,
    input  logic              dual_nop,
    input  logic              ex_trap,
    input  logic              ex_redirect,
    input  logic [ADDR_W-1:0] ex_target,
    input  logic              ext_irq,
    output logic              pair_start,
    output logic              dual_now,
    output half_result_t      res,
    output logic [ADDR_W-1:0] next_pc
);
    logic is_hi;

    always_comb begin
        is_hi      = pc[HALF_BIT];
        pair_start = !in_pair;
        if (is_hi)
            dual_now = in_pair & pair_dual_q;
        else
            dual_now = marks_dual(dual_fp, dual_nop, mode);

        res.irq  = fire && is_hi && (mode == MODE_NONE) && !ex_trap && ext_irq;
        res.trap = fire && (ex_trap || res.irq);
        res.ends = fire && (is_hi || ex_trap || ex_redirect);

        if (!fire)
            next_pc = pc;
        else if (res.trap)
            next_pc = TRAP_VEC;
        else if (ex_redirect)
            next_pc = ex_target;
        else
            next_pc = pc + STEP;
    end
endmodule

// File: rtl/mode_fsm.sv
module mode_fsm
    import dimode_seq_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  half_result_t res,
    input  logic         dual_now,
    output dmode_e       mode
);
    always_ff @(posedge clk) begin
        if (rst)
            mode <= MODE_NONE;
        else if (res.trap)
            mode <= MODE_NONE;
        else if (res.ends)
            mode <= mode_after_pair(mode, dual_now);
    end
endmodule

// File: rtl/seq_regs.sv
module seq_regs #(
    parameter int                ADDR_W   = 32,
    parameter logic [ADDR_W-1:0] TRAP_VEC = '1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fire,
    input  logic [ADDR_W-1:0] next_pc,
    input  logic              pair_end,
    input  logic              pair_start,
    input  logic              dual_now,
    input  logic              cc_set,
    output logic [ADDR_W-1:0] pc,
    output logic              in_pair,
    output logic              pair_dual,
    output logic              cc_valid
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pc        <= TRAP_VEC;
            in_pair   <= 1'b0;
            pair_dual <= 1'b0;
            cc_valid  <= 1'b0;
        end else if (fire) begin
            pc        <= next_pc;
            in_pair   <= !pair_end;
            pair_dual <= dual_now;
            cc_valid  <= (cc_valid & !pair_start) | cc_set;
        end
    end
endmodule

// File: rtl/dimode_pair_seq.sv
module dimode_pair_seq
    import dimode_seq_pkg::*;
#(
    parameter int                ADDR_W   = 32,
    parameter int                INSN_W   = 32,
    parameter logic [ADDR_W-1:0] TRAP_VEC = 32'hFFFF_FF00
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                fetch_valid,
    input  logic [2*INSN_W-1:0] fetch_data,
    input  logic                dec_dual_fp,
    input  logic                dec_dual_nop,
    input  logic                ex_trap,
    input  logic                ex_redirect,
    input  logic [ADDR_W-1:0]   ex_target,
    input  logic                ex_cc_defer,
    input  logic                ext_irq,
    output logic [ADDR_W-1:0]   fetch_addr,
    output logic                issue_valid,
    output logic [INSN_W-1:0]   issue_word,
    output logic                issue_hi,
    output logic [ADDR_W-1:0]   next_pc,
    output logic [1:0]          mode_state,
    output logic                pair_end,
    output logic                trap_enter,
    output logic                irq_trap,
    output logic                cc_defer_valid
);
    localparam int                HALF_BIT = $clog2(INSN_W / 8);
    localparam logic [ADDR_W-1:0] STEP     = ADDR_W'(INSN_W / 8);

    logic         in_pair, pair_dual, pair_start, dual_now;
    dmode_e       mode;
    half_result_t res;

    half_pick #(.INSN_W(INSN_W)) u_pick (
        .pair_word (fetch_data),
        .sel_hi    (fetch_addr[HALF_BIT]),
        .word      (issue_word)
    );

    pair_ctrl #(
        .ADDR_W(ADDR_W), .HALF_BIT(HALF_BIT), .STEP(STEP), .TRAP_VEC(TRAP_VEC)
    ) u_ctrl (
        .fire        (fetch_valid),
        .pc          (fetch_addr),
        .in_pair     (in_pair),
        .pair_dual_q (pair_dual),
        .mode        (mode),
        .dual_fp     (dec_dual_fp),
        .dual_nop    (dec_dual_nop),
        .ex_trap     (ex_trap),
        .ex_redirect (ex_redirect),
        .ex_target   (ex_target),
        .ext_irq     (ext_irq),
        .pair_start  (pair_start),
        .dual_now    (dual_now),
        .res         (res),
        .next_pc     (next_pc)
    );

    mode_fsm u_mode (
        .clk      (clk),
        .rst      (rst),
        .res      (res),
        .dual_now (dual_now),
        .mode     (mode)
    );

    seq_regs #(.ADDR_W(ADDR_W), .TRAP_VEC(TRAP_VEC)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .fire       (fetch_valid),
        .next_pc    (next_pc),
        .pair_end   (res.ends),
        .pair_start (pair_start),
        .dual_now   (dual_now),
        .cc_set     (ex_cc_defer),
        .pc         (fetch_addr),
        .in_pair    (in_pair),
        .pair_dual  (pair_dual),
        .cc_valid   (cc_defer_valid)
    );

    assign issue_valid = fetch_valid;
    assign issue_hi    = fetch_addr[HALF_BIT];
    assign mode_state  = mode;
    assign pair_end    = res.ends;
    assign trap_enter  = res.trap;
    assign irq_trap    = res.irq;
endmodule

// File: rtl/dimode_pair_seq_chk.sv
module dimode_pair_seq_chk #(
    parameter int                ADDR_W   = 32,
    parameter int                INSN_W   = 32,
    parameter logic [ADDR_W-1:0] TRAP_VEC = 32'hFFFF_FF00
) (
    input logic              clk,
    input logic              rst,
    input logic              fetch_valid,
    input logic              ex_trap,
    input logic              ex_redirect,
    input logic              ext_irq,
    input logic [ADDR_W-1:0] fetch_addr,
    input logic              issue_valid,
    input logic              issue_hi,
    input logic [1:0]        mode_state,
    input logic              pair_end,
    input logic              trap_enter,
    input logic              irq_trap
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSN_W / 8);

    assert_reset_state_R1: assert property (@(posedge clk)
        !rst && $past(rst) |-> fetch_addr == TRAP_VEC && mode_state == 2'd0);

    assert_stall_quiet_R3: assert property (@(posedge clk) disable iff (rst)
        !fetch_valid |-> !issue_valid && !pair_end && !trap_enter && !irq_trap);

    assert_stall_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !fetch_valid |=> $stable(fetch_addr) && $stable(mode_state));

    assert_seq_step_R4: assert property (@(posedge clk) disable iff (rst)
        issue_valid && !ex_trap && !irq_trap && !ex_redirect
        |=> fetch_addr == $past(fetch_addr) + STEP);

    assert_trap_vec_R6: assert property (@(posedge clk) disable iff (rst)
        trap_enter |=> fetch_addr == TRAP_VEC && mode_state == 2'd0);

    assert_irq_gate_R7: assert property (@(posedge clk) disable iff (rst)
        irq_trap |-> issue_hi && mode_state == 2'd0 && !ex_trap && ext_irq);

    assert_mode_code_R9: assert property (@(posedge clk) disable iff (rst)
        mode_state != 2'd3);

    assert_full_exit_R9: assert property (@(posedge clk) disable iff (rst)
        mode_state == 2'd2 && !trap_enter |=> mode_state != 2'd0);

    assert_hi_closes_R11: assert property (@(posedge clk) disable iff (rst)
        issue_valid && issue_hi |-> pair_end);
endmodule

bind dimode_pair_seq dimode_pair_seq_chk #(
    .ADDR_W(ADDR_W), .INSN_W(INSN_W), .TRAP_VEC(TRAP_VEC)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .fetch_valid (fetch_valid),
    .ex_trap     (ex_trap),
    .ex_redirect (ex_redirect),
    .ext_irq     (ext_irq),
    .fetch_addr  (fetch_addr),
    .issue_valid (issue_valid),
    .issue_hi    (issue_hi),
    .mode_state  (mode_state),
    .pair_end    (pair_end),
    .trap_enter  (trap_enter),
    .irq_trap    (irq_trap)
);

// File: tb/dimode_pair_seq_bench.sv
module dimode_pair_seq_bench;
    localparam logic [31:0] TV = 32'hFFFF_FF00;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst, fetch_valid, dec_dual_fp, dec_dual_nop;
    logic        ex_trap, ex_redirect, ex_cc_defer, ext_irq;
    logic [63:0] fetch_data;
    logic [31:0] ex_target;
    logic [31:0] fetch_addr, issue_word, next_pc;
    logic        issue_valid, issue_hi, pair_end, trap_enter, irq_trap, cc_defer_valid;
    logic [1:0]  mode_state;

    dimode_pair_seq u_dimode_pair_seq (.*);

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // bench model of the state
    logic [31:0] m_pc;
    logic [1:0]  m_mode;
    bit          m_in_pair, m_pdual, m_cc;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    function automatic logic [1:0] exp_mode_after(input logic [1:0] m, input bit dual);
        if (m == 2'd0) return dual ? 2'd1 : 2'd0;
        if (m == 2'd1) return dual ? 2'd2 : 2'd0;
        return dual ? 2'd2 : 2'd1;
    endfunction

    task automatic step(input bit fv, input bit fp, input bit nop, input bit trp,
                        input bit rdr, input bit cc, input bit irq,
                        input logic [31:0] tgt);
        logic [63:0] d;
        bit          hi, dual, irq_t, trap_t, ends;
        logic [31:0] npc;
        @(negedge clk);
        d = {$urandom(), $urandom()};
        fetch_valid  = fv;
        fetch_data   = d;
        dec_dual_fp  = fp;
        dec_dual_nop = nop;
        ex_trap      = trp;
        ex_redirect  = rdr;
        ex_cc_defer  = cc;
        ext_irq      = irq;
        ex_target    = tgt;
        #1;
        chk(fetch_addr == m_pc, "R4 program counter", fetch_addr, m_pc);
        chk(mode_state == m_mode, "R9 R8 mode", mode_state, m_mode);
        chk(cc_defer_valid == m_cc, "R10 cc flag", cc_defer_valid, m_cc);
        chk(issue_valid == fv, "R3 issue_valid", issue_valid, fv);
        hi = m_pc[2];
        if (!fv) begin
            chk(!pair_end && !trap_enter && !irq_trap, "R3 stall quiet",
                {pair_end, trap_enter, irq_trap}, 0);
            chk(next_pc == m_pc, "R3 stall next_pc", next_pc, m_pc);
        end else begin
            dual   = hi ? (m_in_pair && m_pdual) : (fp || (nop && m_mode != 2'd0));
            irq_t  = hi && m_mode == 2'd0 && !trp && irq;
            trap_t = trp || irq_t;
            ends   = hi || trp || rdr;
            npc    = trap_t ? TV : (rdr ? tgt : m_pc + 32'd4);
            chk(issue_word == (hi ? d[63:32] : d[31:0]), "R2 issue_word",
                issue_word, hi ? d[63:32] : d[31:0]);
            chk(issue_hi == hi, "R2 issue_hi", issue_hi, hi);
            chk(next_pc == npc, "R5 R6 next_pc", next_pc, npc);
            chk(trap_enter == trap_t, "R6 trap_enter", trap_enter, trap_t);
            chk(irq_trap == irq_t, "R7 irq_trap", irq_trap, irq_t);
            chk(pair_end == ends, "R11 pair_end", pair_end, ends);
            // model update for the coming edge
            if (trap_t) m_mode = 2'd0;
            else if (ends) m_mode = exp_mode_after(m_mode, dual);
            m_cc      = (m_cc && m_in_pair) || cc;
            m_pdual   = dual;
            m_in_pair = !ends;
            m_pc      = npc;
        end
    endtask

    initial begin
        #1_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1;
        fetch_valid = 0; fetch_data = '0; dec_dual_fp = 0; dec_dual_nop = 0;
        ex_trap = 0; ex_redirect = 0; ex_cc_defer = 0; ext_irq = 0; ex_target = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        chk(fetch_addr == TV, "R1 reset pc", fetch_addr, TV);
        chk(mode_state == 2'd0, "R1 reset mode", mode_state, 0);
        chk(cc_defer_valid == 1'b0, "R1 reset cc", cc_defer_valid, 0);
        rst = 1'b0;
        m_pc = TV; m_mode = 2'd0; m_in_pair = 0; m_pdual = 0; m_cc = 0;

        // R8/R9 walk: single -> trans -> full
        step(1, 1, 0, 0, 0, 1, 0, 0);  step(1, 0, 0, 0, 0, 0, 0, 0);
        step(1, 1, 0, 0, 0, 0, 0, 0);  step(1, 0, 0, 0, 0, 0, 0, 0);
        // nop counts while in dual mode; high-half flags ignored
        step(1, 0, 1, 0, 0, 0, 0, 0);  step(1, 1, 1, 0, 0, 0, 0, 0);
        // R7 request in full mode ignored; full -> trans
        step(1, 0, 0, 0, 0, 0, 1, 0);  step(1, 0, 0, 0, 0, 0, 1, 0);
        // R3 stall
        step(0, 1, 1, 1, 1, 1, 1, 32'h40);
        // trans -> single
        step(1, 0, 0, 0, 0, 0, 0, 0);  step(1, 0, 0, 0, 0, 0, 0, 0);
        // R8 nop in single mode does not mark the pair
        step(1, 0, 1, 0, 0, 0, 0, 0);  step(1, 0, 0, 0, 0, 0, 0, 0);
        // R7 request on low half ignored, taken on high half
        step(1, 0, 0, 0, 0, 0, 1, 0);  step(1, 0, 0, 0, 0, 0, 1, 0);
        // R5 redirect to a high-half address, R6 trap beats redirect
        step(1, 0, 0, 0, 1, 0, 0, 32'h0000_1004);
        step(1, 1, 0, 0, 0, 0, 0, 0);
        step(1, 0, 0, 1, 1, 0, 0, 32'h0000_2000);

        for (int i = 0; i < 6000; i++) begin
            step(($urandom() % 8) != 0, ($urandom() % 3) == 0, ($urandom() % 4) == 0,
                 ($urandom() % 16) == 0, ($urandom() % 8) == 0, ($urandom() % 4) == 0,
                 ($urandom() % 3) == 0, $urandom() & 32'hFFFF_FFFC);
        end
        finish_run();
    end
endmodule